// File: doc/BRIEF.md
# Input Transition and Interrupt Detector

This block watches a bank of nine asynchronous input pins. It keeps two sticky status flags that read as active-low. The change flag drops to 0 when any monitored pin changes level. The alert flag drops to 0 only when a monitored pin whose per-pin alert enable is set changes level. Both flags stay at 0 until software reads the status, which the block sees as a one-cycle read strobe. A transition that arrives in the same cycle as the strobe wins, so no event is lost.

Every pin passes through a two-flop synchronizer. A change is found by comparing the newest synchronized sample with the one taken a cycle earlier. A configuration input selects the role of pin index 0:

- **Alert output:** pin 0 is an open-drain output that pulls low while the alert flag is 0. Its own input is then left out of detection.
- **General-purpose pin:** pin 0 is driven from its port-register level and is monitored like any other pin.

A second configuration input turns detection off completely.

Top module: `pin_event_monitor`

## Requirements
- R1: After reset, `chg_flag_n` and `alert_flag_n` read 1. With `cfg_p0_gpio` = 0, `p0_pull_low` reads 0.
- R2: A level change in either direction on a monitored pin of `pin_raw`, applied before rising edge E1, drives `chg_flag_n` to 0 after the third rising edge (E3) and not before it.
- R3: `alert_flag_n` goes to 0 only when a changing monitored pin has its bit set in `alert_en`. A change on a pin whose `alert_en` bit is 0 leaves `alert_flag_n` at 1.
- R4: Once either flag is 0, it stays 0 while `stat_rd` is low, whatever the pins do.
- R5: A one-cycle high pulse on `stat_rd` with no change pending returns both flags to 1 at the next rising edge.
- R6: When a change is detected in the same cycle as `stat_rd`, the affected flags end that cycle at 0.
- R7: While `cfg_det_off` is 1, no pin change alters either flag.
- R8: With `cfg_p0_gpio` = 0, `p0_pull_low` is 1 exactly while `alert_flag_n` is 0, and changes on pin index 0 are ignored by both flags.
- R9: With `cfg_p0_gpio` = 1, `p0_pull_low` is the inverse of `p0_level`, and pin index 0 is monitored like the other pins.
- R10: The level that the pins hold when reset is released is not reported as a change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_raw | input | 9 | Asynchronous input pin levels, index 0 is the shared pin |
| alert_en | input | 9 | Per-pin alert enable from the port registers |
| cfg_p0_gpio | input | 1 | 0: pin 0 is the alert output; 1: pin 0 is general-purpose |
| cfg_det_off | input | 1 | 1 disables change detection; 0 enables it |
| p0_level | input | 1 | Port-register level for pin 0 in general-purpose mode |
| stat_rd | input | 1 | One-cycle status read strobe |
| chg_flag_n | output | 1 | Sticky change flag, 0 = a change occurred |
| alert_flag_n | output | 1 | Sticky alert flag, 0 = an enabled change occurred |
| p0_pull_low | output | 1 | 1 = open-drain pull-down active on pin 0 |

## Verification
The two flag registers hold all of the block's visible state. A wrong value in either register shows up on its flag output on the very next cycle. In alert mode, a wrong alert flag also shows up at the same moment on `p0_pull_low`.

A fault in the synchronizer or in the previous-sample register shows up differently: a flag falls one cycle early or late, or falls when a pin is stable. The bench samples the edges just around E3 to catch this.

A wrong priming counter reports the level held at reset release as a change. This becomes visible a few cycles after reset.

// File: rtl/pin_event_pkg.sv
package pin_event_pkg;

  // Role of the shared pin and the detection on/off control.
  typedef struct packed {
    logic p0_gpio;
    logic det_off;
  } evt_cfg_t;

  // Flag pair, active-low.
  typedef struct packed {
    logic chg_n;
    logic alert_n;
  } evt_flags_t;

endpackage

// File: rtl/pem_rst_sync.sv
module pem_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) chain_q <= '0;
    else              chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/pem_in_sync.sv
module pem_in_sync #(
  parameter int W      = 9,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  always_comb begin
    stg_d[0] = din;
    for (int s = 1; s < STAGES; s++) stg_d[s] = stg_q[s-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= '0;
    else        stg_q <= stg_d;
  end

  assign dout = stg_q[STAGES-1];

endmodule

// File: rtl/pem_change_det.sv
module pem_change_det #(
  parameter int W    = 9,
  parameter int FILL = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cur,
  output logic [W-1:0] delta,
  output logic         primed
);

  localparam int CW = $clog2(FILL + 1);

  logic [W-1:0]  prev_q;
  logic [CW-1:0] fill_q;
  logic [CW-1:0] fill_d;
  logic          fill_en;

  assign primed  = (fill_q == CW'(FILL));
  assign fill_en = !primed;

  always_comb begin
    fill_d = fill_q;
    if (fill_en) fill_d = fill_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      fill_q <= '0;
    end else begin
      prev_q <= cur;
      fill_q <= fill_d;
    end
  end

  assign delta = primed ? (cur ^ prev_q) : '0;

endmodule

// File: rtl/pem_flag_ctl.sv
module pem_flag_ctl
  import pin_event_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chg_evt,
  input  logic       alert_evt,
  input  logic       rd_stb,
  output evt_flags_t flags
);

  evt_flags_t flags_q;
  evt_flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (rd_stb) begin
      flags_d.chg_n   = 1'b1;
      flags_d.alert_n = 1'b1;
    end
    // A new event overrides a read in the same cycle.
    if (chg_evt)   flags_d.chg_n   = 1'b0;
    if (alert_evt) flags_d.alert_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '{chg_n: 1'b1, alert_n: 1'b1};
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;

endmodule

// File: rtl/pin_event_monitor.sv
module pin_event_monitor
  import pin_event_pkg::*;
#(
  parameter int NUM_PINS    = 9,
  parameter int SYNC_STAGES = 2,
  parameter int SHARED_PIN  = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_raw,
  input  logic [NUM_PINS-1:0] alert_en,
  input  logic                cfg_p0_gpio,
  input  logic                cfg_det_off,
  input  logic                p0_level,
  input  logic                stat_rd,
  output logic                chg_flag_n,
  output logic                alert_flag_n,
  output logic                p0_pull_low
);

  localparam int                FILL       = SYNC_STAGES + 1;
  localparam logic [NUM_PINS-1:0] SHARED_BIT = NUM_PINS'(1) << SHARED_PIN;

  evt_cfg_t             cfg;
  evt_flags_t           flags;
  logic                 rst_core_n;
  logic [NUM_PINS-1:0]  pin_sync;
  logic [NUM_PINS-1:0]  delta;
  logic [NUM_PINS-1:0]  watch_mask;
  logic                 primed;
  logic                 chg_evt;
  logic                 alert_evt;

  assign cfg = '{p0_gpio: cfg_p0_gpio, det_off: cfg_det_off};

  pem_rst_sync #(.STAGES(2)) u_rst (
    .clk         (clk),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_core_n)
  );

  pem_in_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_core_n),
    .din   (pin_raw),
    .dout  (pin_sync)
  );

  pem_change_det #(.W(NUM_PINS), .FILL(FILL)) u_det (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .cur    (pin_sync),
    .delta  (delta),
    .primed (primed)
  );

  // The shared pin is left out while it serves as the alert output.
  assign watch_mask = cfg.p0_gpio ? '1 : ~SHARED_BIT;

  always_comb begin
    chg_evt   = 1'b0;
    alert_evt = 1'b0;
    if (!cfg.det_off && primed) begin
      chg_evt   = |(delta & watch_mask);
      alert_evt = |(delta & watch_mask & alert_en);
    end
  end

  pem_flag_ctl u_flags (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .chg_evt   (chg_evt),
    .alert_evt (alert_evt),
    .rd_stb    (stat_rd),
    .flags     (flags)
  );

  assign chg_flag_n   = flags.chg_n;
  assign alert_flag_n = flags.alert_n;

  // Open-drain: only a pull-down is ever driven.
  assign p0_pull_low = cfg.p0_gpio ? !p0_level : !flags.alert_n;

endmodule

// File: rtl/pem_checker.sv
module pem_checker (
  input logic clk,
  input logic rst_n,
  input logic stat_rd,
  input logic cfg_det_off,
  input logic chg_evt,
  input logic alert_evt,
  input logic chg_flag_n,
  input logic alert_flag_n
);

  // R3: an enabled alert is always also a change
  p_alert_implies_chg_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_flag_n |-> !chg_flag_n);

  // R4: flags are sticky until a read
  p_chg_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!chg_flag_n && !stat_rd) |=> !chg_flag_n);

  p_alert_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_flag_n && !stat_rd) |=> !alert_flag_n);

  // R5: a read with nothing pending restores idle
  p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !chg_evt && !alert_evt) |=> (chg_flag_n && alert_flag_n));

  // R6: an event beats a concurrent read
  p_event_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && chg_evt) |=> !chg_flag_n);

  // R7: detection disabled leaves an idle flag idle
  p_det_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_det_off && chg_flag_n) |=> chg_flag_n);

endmodule

bind pin_event_monitor pem_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stat_rd      (stat_rd),
  .cfg_det_off  (cfg_det_off),
  .chg_evt      (chg_evt),
  .alert_evt    (alert_evt),
  .chg_flag_n   (chg_flag_n),
  .alert_flag_n (alert_flag_n)
);

// File: tb/tb_pin_event_monitor.sv
module tb_pin_event_monitor;

  localparam int N = 9;

  logic         clk;
  logic         rst_n;
  logic [N-1:0] pin_raw;
  logic [N-1:0] alert_en;
  logic         cfg_p0_gpio;
  logic         cfg_det_off;
  logic         p0_level;
  logic         stat_rd;
  logic         chg_flag_n;
  logic         alert_flag_n;
  logic         p0_pull_low;

  int n_chk  = 0;
  int n_fail = 0;
  bit exp_chg_n;
  bit exp_alert_n;

  pin_event_monitor dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .pin_raw      (pin_raw),
    .alert_en     (alert_en),
    .cfg_p0_gpio  (cfg_p0_gpio),
    .cfg_det_off  (cfg_det_off),
    .p0_level     (p0_level),
    .stat_rd      (stat_rd),
    .chg_flag_n   (chg_flag_n),
    .alert_flag_n (alert_flag_n),
    .p0_pull_low  (p0_pull_low)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic check_eq(input string req, input int act, input int exp_v);
    n_chk++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp_v);
    end
  endtask

  // Pins that count toward the flags under a given shared-pin role.
  function automatic logic [N-1:0] watched(input logic [N-1:0] tog, input logic gpio);
    return gpio ? tog : (tog & ~N'(1));
  endfunction

  function automatic bit exp_pull(input bit gpio, input bit lvl, input bit alert_n);
    return gpio ? !lvl : !alert_n;
  endfunction

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic read_status();
    stat_rd = 1'b1;
    tick();
    stat_rd = 1'b0;
  endtask

  task automatic check_flags(input string tag);
    check_eq({tag, " chg"},   chg_flag_n,   exp_chg_n);
    check_eq({tag, " alert"}, alert_flag_n, exp_alert_n);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [N-1:0] tog;
    logic [N-1:0] eff;
    void'($urandom(32'd2024));

    rst_n       = 1'b0;
    pin_raw     = '1;   // R10: held high across reset release
    alert_en    = '0;
    cfg_p0_gpio = 1'b0;
    cfg_det_off = 1'b0;
    p0_level    = 1'b1;
    stat_rd     = 1'b0;
    settle(4);
    rst_n = 1'b1;
    settle(10);

    exp_chg_n   = 1;
    exp_alert_n = 1;
    check_flags("R1 R10 reset");
    check_eq("R1 pull", p0_pull_low, 0);

    // R2 timing and R3: change on pin 4 (not enabled)
    alert_en   = 9'h008;
    pin_raw[4] = 1'b0;
    tick();
    tick();
    check_eq("R2 before E3", chg_flag_n, 1);
    tick();
    check_eq("R2 at E3", chg_flag_n, 0);
    check_eq("R3 disabled pin", alert_flag_n, 1);

    // R4: more changes with no read keep the flag low
    pin_raw[4] = 1'b1;
    settle(5);
    check_eq("R4 sticky", chg_flag_n, 0);

    read_status();
    exp_chg_n = 1;
    check_flags("R5 read");

    // R6: strobe during the detect cycle; enabled pin 3 falls
    pin_raw[3] = 1'b0;
    tick();
    tick();
    stat_rd = 1'b1;
    tick();
    stat_rd = 1'b0;
    exp_chg_n   = 0;
    exp_alert_n = 0;
    check_flags("R6 event wins");
    check_eq("R8 pull follows alert", p0_pull_low, 1);

    read_status();
    exp_chg_n   = 1;
    exp_alert_n = 1;
    check_flags("R5 read2");
    check_eq("R8 pull released", p0_pull_low, 0);

    // R8: shared pin is ignored in alert mode
    alert_en   = '1;
    pin_raw[0] = 1'b0;
    settle(5);
    check_flags("R8 shared pin ignored");

    // R9: general-purpose mode monitors pin 0; pull follows level
    cfg_p0_gpio = 1'b1;
    p0_level    = 1'b1;
    settle(2);
    check_eq("R9 pull level1", p0_pull_low, 0);
    pin_raw[0] = 1'b1;
    settle(5);
    exp_chg_n   = 0;
    exp_alert_n = 0;
    check_flags("R9 pin0 watched");
    p0_level = 1'b0;
    tick();
    check_eq("R9 pull level0", p0_pull_low, 1);
    read_status();
    exp_chg_n   = 1;
    exp_alert_n = 1;

    // R7: detection off
    cfg_det_off = 1'b1;
    pin_raw     = ~pin_raw;
    settle(5);
    check_flags("R7 det off");
    cfg_det_off = 1'b0;
    settle(2);

    // Random mix
    for (int it = 0; it < 60; it++) begin
      tick();
      alert_en    = N'($urandom);
      cfg_p0_gpio = 1'($urandom);
      cfg_det_off = (($urandom % 4) == 0);
      p0_level    = 1'($urandom);
      tog         = N'($urandom) & N'($urandom);
      pin_raw     = pin_raw ^ tog;
      eff         = watched(tog, cfg_p0_gpio);
      if (!cfg_det_off) begin
        if (eff != '0)              exp_chg_n   = 0;
        if ((eff & alert_en) != '0) exp_alert_n = 0;
      end
      settle(5);
      check_flags("R2 R3 R4 R7 random");
      check_eq("R8 R9 random pull", p0_pull_low,
               exp_pull(cfg_p0_gpio, p0_level, exp_alert_n));
      if (($urandom % 3) == 0) begin
        read_status();
        exp_chg_n   = 1;
        exp_alert_n = 1;
        check_flags("R5 random read");
      end
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule